// File: doc/BRIEF.md
# Descriptor Chain Channel Sequencer

This block is the control state machine of one descriptor-driven DMA channel. Software programs the 64-bit start pointers of a source and a destination descriptor. It then writes a control word that carries three bits: enable, continue, and continue-from-start. The sequencer fetches the destination descriptor, then walks the source descriptors one by one. It hands each source descriptor, together with the current destination descriptor, to a separate data mover through a start/done handshake.

Each descriptor is 16 bytes and ends with a command that can let the chain run on, halt it, or stop it. The next source descriptor is either contiguous in memory or found through a 64-bit pointer that is stored just after the current descriptor. A halted chain can resume at the following descriptor or restart from the programmed start pointers. In register-pointer mode no memory is read: both descriptors come straight from register copies, and one descriptor is processed before the channel stops.

Descriptors are read over a valid/ready request with 32-bit response beats. The channel reports a 2-bit state and single-cycle event strobes. The data movement itself and the interrupt register file live in other blocks.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the status reads 0 (disabled), the enable and continue bits read 0, and no read request or mover start is issued.
- R2: A control write with enable = 1 while disabled clears the error flag and copies both start pointers into the current pointers. The status reads 1 (enabled) in the cycle after the write, and the destination descriptor is fetched before the first source descriptor.
- R3: A descriptor is four 32-bit words, returned as four beats with word 0 first and the request address equal to the descriptor pointer. Word 0 holds address bits 31:0 and word 1 holds address bits 48:32 in bits 16:0. Word 2 holds the byte size in bits 29:0. Word 3 holds the command in bits 4:3, the interrupt flag in bit 2, the type in bit 1 (0 linear, 1 linked) and the coherent flag in bit 0. The mover receives the words unchanged as {w3,w2,w1,w0} with a one-cycle start pulse.
- R4: With memory mode off (register-pointer mode), no read request is made. The mover gets the register descriptor copies, and after that one descriptor the enable bit clears and the status returns to 0.
- R5: Every completed source descriptor pulses the done event. The source-done event pulses in the same cycle only when that descriptor's interrupt flag is set.
- R6: A completed descriptor with command 2 (stop) clears the enable bit and sets the status to 0.
- R7: A completed descriptor with command 1 (halt) sets the status to 2 (paused), pulses the pause event, and keeps the source pointer on the halting descriptor.
- R8: After a descriptor of type linear with command 0, the source pointer advances by 16 and the next descriptor is fetched there.
- R9: After a descriptor of type linked, a two-beat read at the source pointer plus 16 returns the next pointer, low word first, and the source pointer takes that value.
- R10: A write with enable = 1 and continue = 1 while paused, with continue-from-start = 0, advances to the following descriptor. The continue bit reads 0 and the status reads 1 in the cycle after the write.
- R11: A write with enable = 1, continue = 1 and continue-from-start = 1 while paused reloads both pointers from the start inputs, fetches the destination descriptor again, and restarts the chain at the source start.
- R12: While paused, a write with enable = 0 and continue = 1 sets the status to 0 in the next cycle. A write with enable = 1 and continue = 0 has no effect: the status stays 2 and no request or start follows.
- R13: In memory mode, a source or destination descriptor pointer whose low four bits are not zero is not requested. The matching source-error or destination-error event pulses and the status reads 3 until a later write with enable = 1 clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_mode_i | input | 1 | 1: descriptors fetched from memory; 0: register-pointer mode |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Enable bit of the control write |
| ctrl_cont_i | input | 1 | Continue bit of the control write |
| ctrl_cont_start_i | input | 1 | Continue-from-start bit of the control write |
| src_start_i | input | 64 | Source descriptor start pointer |
| dst_start_i | input | 64 | Destination descriptor start pointer |
| src_reg_dscr_i | input | 128 | Register copy of the source descriptor {w3,w2,w1,w0} |
| dst_reg_dscr_i | input | 128 | Register copy of the destination descriptor {w3,w2,w1,w0} |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | 64 | Read request byte address |
| rd_req_ptr_o | output | 1 | 1: two-beat next-pointer read; 0: four-beat descriptor read |
| rd_rsp_valid_i | input | 1 | Response beat valid |
| rd_rsp_data_i | input | 32 | Response beat data |
| mv_start_o | output | 1 | One-cycle start pulse to the data mover |
| mv_done_i | input | 1 | Data mover finished the current descriptor |
| mv_src_dscr_o | output | 128 | Current source descriptor |
| mv_dst_dscr_o | output | 128 | Current destination descriptor |
| src_cur_o | output | 64 | Current source descriptor pointer |
| dst_cur_o | output | 64 | Current destination descriptor pointer |
| status_o | output | 2 | 0 disabled, 1 enabled, 2 paused, 3 error |
| en_o | output | 1 | Enable bit |
| cont_o | output | 1 | Continue bit |
| ev_done_o | output | 1 | Descriptor done event |
| ev_src_done_o | output | 1 | Source-done event (interrupt flag set) |
| ev_pause_o | output | 1 | Pause event |
| ev_src_err_o | output | 1 | Source descriptor read error event |
| ev_dst_err_o | output | 1 | Destination descriptor read error event |

## Verification
Status, enable and continue are registered. They change at the clock edge that takes a control write, so the bench drives each write at a falling edge and checks these outputs at the next falling edge, one cycle later. Events and the post-descriptor state all change at the edge that takes mv_done_i. Fetch and mover latency depends on the response models, so the bench waits until the status leaves 1 and then compares event, request and start counts, the final pointers and the captured descriptors. The counters are updated at rising edges, from values that settled half a cycle earlier. Request valid, request address and mover start are combinational from registered phase state, so the response and mover models read them at falling edges.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {CH_OFF = 2'd0, CH_RUN = 2'd1, CH_HOLD = 2'd2} chan_st_e;
  typedef enum logic [2:0] {PH_IDLE, PH_REQ, PH_RSP, PH_MOVE, PH_ADV} phase_e;
  typedef enum logic [1:0] {K_DST, K_SRC, K_PTR} fetch_e;

  localparam logic [1:0] CMD_HALT = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;
  // bit positions inside descriptor word 3
  localparam int W3_CMD_LSB = 3;
  localparam int W3_INTR    = 2;
  localparam int W3_TYPE    = 1;
endpackage

// File: rtl/dcs_beat_asm.sv
module dcs_beat_asm #(
  parameter int BEAT_W    = 32,
  parameter int MAX_BEATS = 4,
  localparam int CNT_W    = $clog2(MAX_BEATS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        beat_valid_i,
  input  logic [BEAT_W-1:0]           beat_data_i,
  input  logic [CNT_W-1:0]            last_idx_i,
  output logic                        last_o,
  output logic [MAX_BEATS*BEAT_W-1:0] words_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BEAT_W-1:0] slot_q [MAX_BEATS];

  assign last_o = beat_valid_i && (cnt_q == last_idx_i);

  // present the beat arriving this cycle in its slot so the last one is usable at once
  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    assign words_o[g*BEAT_W +: BEAT_W] =
      (beat_valid_i && cnt_q == CNT_W'(g)) ? beat_data_i : slot_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (!clr_i && beat_valid_i && cnt_q == CNT_W'(g)) slot_q[g] <= beat_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (beat_valid_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int BEAT_W     = 32,
  parameter int DSCR_WORDS = 4,
  parameter int PTR_WORDS  = 2,
  localparam int DSCR_W     = DSCR_WORDS * BEAT_W,
  localparam int DSCR_BYTES = DSCR_W / 8,
  localparam int ALIGN_W    = $clog2(DSCR_BYTES),
  localparam int CNT_W      = $clog2(DSCR_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_mode_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_cont_i,
  input  logic              ctrl_cont_start_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [DSCR_W-1:0] src_reg_dscr_i,
  input  logic [DSCR_W-1:0] dst_reg_dscr_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  output logic              rd_req_ptr_o,
  output logic              asm_clr_o,
  output logic [CNT_W-1:0]  asm_last_idx_o,
  input  logic              asm_last_i,
  input  logic [DSCR_W-1:0] asm_words_i,
  output logic              mv_start_o,
  input  logic              mv_done_i,
  output logic [DSCR_W-1:0] src_dscr_o,
  output logic [DSCR_W-1:0] dst_dscr_o,
  output logic [ADDR_W-1:0] src_cur_o,
  output logic [ADDR_W-1:0] dst_cur_o,
  output logic [1:0]        status_o,
  output logic              en_o,
  output logic              cont_o,
  output logic              ev_done_o,
  output logic              ev_src_done_o,
  output logic              ev_pause_o,
  output logic              ev_src_err_o,
  output logic              ev_dst_err_o
);
  chan_st_e          st_q;
  phase_e            ph_q;
  fetch_e            kind_q;
  logic              err_q, en_q, cont_q, cs_q, issued_q;
  logic [ADDR_W-1:0] src_cur_q, dst_cur_q, fetch_addr;
  logic [DSCR_W-1:0] src_dscr_q, dst_dscr_q;
  logic              misalign_err;
  logic [1:0]        src_cmd;
  logic              src_intr, src_linked;

  always_comb begin
    unique case (kind_q)
      K_DST:   fetch_addr = dst_cur_q;
      K_SRC:   fetch_addr = src_cur_q;
      default: fetch_addr = src_cur_q + ADDR_W'(DSCR_BYTES);
    endcase
  end

  assign misalign_err   = mem_mode_i && (kind_q != K_PTR) && (|fetch_addr[ALIGN_W-1:0]);
  assign rd_req_valid_o = (ph_q == PH_REQ) && !misalign_err && (mem_mode_i || kind_q == K_PTR);
  assign rd_req_addr_o  = fetch_addr;
  assign rd_req_ptr_o   = (kind_q == K_PTR);
  assign asm_clr_o      = (ph_q != PH_RSP);
  assign asm_last_idx_o = (kind_q == K_PTR) ? CNT_W'(PTR_WORDS - 1) : CNT_W'(DSCR_WORDS - 1);
  assign mv_start_o     = (ph_q == PH_MOVE) && !issued_q;

  assign src_cmd    = src_dscr_q[3*BEAT_W + W3_CMD_LSB +: 2];
  assign src_intr   = src_dscr_q[3*BEAT_W + W3_INTR];
  assign src_linked = src_dscr_q[3*BEAT_W + W3_TYPE];

  assign src_dscr_o = src_dscr_q;
  assign dst_dscr_o = dst_dscr_q;
  assign src_cur_o  = src_cur_q;
  assign dst_cur_o  = dst_cur_q;
  assign status_o   = err_q ? 2'd3 : st_q;
  assign en_o       = en_q;
  assign cont_o     = cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CH_OFF;  ph_q <= PH_IDLE;  kind_q <= K_DST;
      err_q <= 1'b0;  en_q <= 1'b0;  cont_q <= 1'b0;  cs_q <= 1'b0;  issued_q <= 1'b0;
      src_cur_q <= '0;  dst_cur_q <= '0;  src_dscr_q <= '0;  dst_dscr_q <= '0;
      ev_done_o <= 1'b0;  ev_src_done_o <= 1'b0;  ev_pause_o <= 1'b0;
      ev_src_err_o <= 1'b0;  ev_dst_err_o <= 1'b0;
    end else begin
      ev_done_o <= 1'b0;  ev_src_done_o <= 1'b0;  ev_pause_o <= 1'b0;
      ev_src_err_o <= 1'b0;  ev_dst_err_o <= 1'b0;
      if (ctrl_we_i) begin
        en_q   <= ctrl_en_i;
        cont_q <= ctrl_cont_i;
        cs_q   <= ctrl_cont_start_i;
        if (ctrl_en_i) err_q <= 1'b0;
      end
      unique case (ph_q)
        PH_IDLE: if (ctrl_we_i) begin
          if (ctrl_en_i) begin
            if (st_q == CH_HOLD && ctrl_cont_i) begin
              cont_q <= 1'b0;
              st_q   <= CH_RUN;
              if (ctrl_cont_start_i) begin
                src_cur_q <= src_start_i;  dst_cur_q <= dst_start_i;
                kind_q <= K_DST;  ph_q <= PH_REQ;
              end else begin
                ph_q <= PH_ADV;
              end
            end else if (st_q == CH_OFF) begin
              src_cur_q <= src_start_i;  dst_cur_q <= dst_start_i;
              st_q <= CH_RUN;  kind_q <= K_DST;  ph_q <= PH_REQ;
            end
          end else if (st_q == CH_HOLD && ctrl_cont_i) begin
            st_q <= CH_OFF;
          end
        end
        PH_REQ: begin
          if (misalign_err) begin
            err_q        <= 1'b1;
            ev_src_err_o <= (kind_q == K_SRC);
            ev_dst_err_o <= (kind_q == K_DST);
            st_q <= CH_OFF;  ph_q <= PH_IDLE;
          end else if (!mem_mode_i && kind_q == K_DST) begin
            dst_dscr_q <= dst_reg_dscr_i;  kind_q <= K_SRC;
          end else if (!mem_mode_i && kind_q == K_SRC) begin
            src_dscr_q <= src_reg_dscr_i;  ph_q <= PH_MOVE;
          end else if (rd_req_ready_i) begin
            ph_q <= PH_RSP;
          end
        end
        PH_RSP: if (asm_last_i) begin
          unique case (kind_q)
            K_DST:   begin dst_dscr_q <= asm_words_i;  kind_q <= K_SRC;  ph_q <= PH_REQ; end
            K_SRC:   begin src_dscr_q <= asm_words_i;  ph_q <= PH_MOVE; end
            default: begin src_cur_q <= asm_words_i[ADDR_W-1:0];  kind_q <= K_SRC;  ph_q <= PH_REQ; end
          endcase
        end
        PH_MOVE: begin
          if (!issued_q) begin
            issued_q <= 1'b1;
          end else if (mv_done_i) begin
            issued_q      <= 1'b0;
            ev_done_o     <= 1'b1;
            ev_src_done_o <= src_intr;
            if (!mem_mode_i || src_cmd == CMD_STOP) begin
              en_q <= 1'b0;  st_q <= CH_OFF;  ph_q <= PH_IDLE;
            end else if (src_cmd == CMD_HALT) begin
              st_q <= CH_HOLD;  ev_pause_o <= 1'b1;  ph_q <= PH_IDLE;
            end else begin
              ph_q <= PH_ADV;
            end
          end
        end
        PH_ADV: begin
          if (src_linked) begin
            kind_q <= K_PTR;
          end else begin
            src_cur_q <= src_cur_q + ADDR_W'(DSCR_BYTES);
            kind_q    <= K_SRC;
          end
          ph_q <= PH_REQ;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int ADDR_W     = 64,
  parameter int BEAT_W     = 32,
  parameter int DSCR_WORDS = 4,
  parameter int PTR_WORDS  = 2,
  localparam int DSCR_W    = DSCR_WORDS * BEAT_W,
  localparam int CNT_W     = $clog2(DSCR_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_mode_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_en_i,
  input  logic              ctrl_cont_i,
  input  logic              ctrl_cont_start_i,
  input  logic [ADDR_W-1:0] src_start_i,
  input  logic [ADDR_W-1:0] dst_start_i,
  input  logic [DSCR_W-1:0] src_reg_dscr_i,
  input  logic [DSCR_W-1:0] dst_reg_dscr_i,
  output logic              rd_req_valid_o,
  input  logic              rd_req_ready_i,
  output logic [ADDR_W-1:0] rd_req_addr_o,
  output logic              rd_req_ptr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [BEAT_W-1:0] rd_rsp_data_i,
  output logic              mv_start_o,
  input  logic              mv_done_i,
  output logic [DSCR_W-1:0] mv_src_dscr_o,
  output logic [DSCR_W-1:0] mv_dst_dscr_o,
  output logic [ADDR_W-1:0] src_cur_o,
  output logic [ADDR_W-1:0] dst_cur_o,
  output logic [1:0]        status_o,
  output logic              en_o,
  output logic              cont_o,
  output logic              ev_done_o,
  output logic              ev_src_done_o,
  output logic              ev_pause_o,
  output logic              ev_src_err_o,
  output logic              ev_dst_err_o
);
  logic              asm_clr, asm_last;
  logic [CNT_W-1:0]  asm_last_idx;
  logic [DSCR_W-1:0] asm_words;

  dcs_beat_asm #(.BEAT_W(BEAT_W), .MAX_BEATS(DSCR_WORDS)) u_asm (
    .clk_i, .rst_ni,
    .clr_i        (asm_clr),
    .beat_valid_i (rd_rsp_valid_i),
    .beat_data_i  (rd_rsp_data_i),
    .last_idx_i   (asm_last_idx),
    .last_o       (asm_last),
    .words_o      (asm_words)
  );

  dcs_ctrl #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .DSCR_WORDS(DSCR_WORDS), .PTR_WORDS(PTR_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .mem_mode_i,
    .ctrl_we_i, .ctrl_en_i, .ctrl_cont_i, .ctrl_cont_start_i,
    .src_start_i, .dst_start_i, .src_reg_dscr_i, .dst_reg_dscr_i,
    .rd_req_valid_o, .rd_req_ready_i, .rd_req_addr_o, .rd_req_ptr_o,
    .asm_clr_o      (asm_clr),
    .asm_last_idx_o (asm_last_idx),
    .asm_last_i     (asm_last),
    .asm_words_i    (asm_words),
    .mv_start_o, .mv_done_i,
    .src_dscr_o     (mv_src_dscr_o),
    .dst_dscr_o     (mv_dst_dscr_o),
    .src_cur_o, .dst_cur_o, .status_o, .en_o, .cont_o,
    .ev_done_o, .ev_src_done_o, .ev_pause_o, .ev_src_err_o, .ev_dst_err_o
  );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_req_valid_o,
  input logic              rd_req_ready_i,
  input logic [ADDR_W-1:0] rd_req_addr_o,
  input logic              mv_start_o,
  input logic [1:0]        status_o,
  input logic              en_o,
  input logic              ev_done_o,
  input logic              ev_src_done_o,
  input logic              ev_pause_o,
  input logic              ev_src_err_o,
  input logic              ev_dst_err_o
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));
  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_start_o |=> !mv_start_o);
  // R5
  src_done_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_src_done_o |-> ev_done_o);
  // R6
  stop_clears_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_done_o && status_o == 2'd0 |-> !en_o);
  // R7
  pause_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_pause_o |-> status_o == 2'd2);
  // R13
  src_err_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_src_err_o |-> status_o == 2'd3);
  // R13
  dst_err_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_dst_err_o |-> status_o == 2'd3);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chain_seq_bench.sv
`timescale 1ns/1ps
module dma_chain_seq_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mem_mode, ctrl_we, ctrl_en, ctrl_cont, ctrl_cs;
  logic [63:0]  src_start, dst_start;
  logic [127:0] src_reg, dst_reg;
  logic         rd_req_valid, rd_req_ready, rd_req_ptr;
  logic [63:0]  rd_req_addr;
  logic         rd_rsp_valid;
  logic [31:0]  rd_rsp_data;
  logic         mv_start, mv_done;
  logic [127:0] mv_src, mv_dst;
  logic [63:0]  src_cur, dst_cur;
  logic [1:0]   status;
  logic         en, cont;
  logic         ev_done, ev_src_done, ev_pause, ev_src_err, ev_dst_err;

  int total = 0, bad = 0;
  int req_cnt = 0, start_cnt = 0, done_cnt = 0, sdone_cnt = 0, pause_cnt = 0;
  int serr_cnt = 0, derr_cnt = 0;
  logic [63:0]  last_ptr_addr = '0;
  logic [127:0] last_src = '0, last_dst = '0;
  logic [31:0]  mem [0:127];

  always #2.5 clk = ~clk;

  dma_chain_seq u_dma_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .mem_mode_i(mem_mode),
    .ctrl_we_i(ctrl_we), .ctrl_en_i(ctrl_en), .ctrl_cont_i(ctrl_cont), .ctrl_cont_start_i(ctrl_cs),
    .src_start_i(src_start), .dst_start_i(dst_start),
    .src_reg_dscr_i(src_reg), .dst_reg_dscr_i(dst_reg),
    .rd_req_valid_o(rd_req_valid), .rd_req_ready_i(rd_req_ready), .rd_req_addr_o(rd_req_addr),
    .rd_req_ptr_o(rd_req_ptr), .rd_rsp_valid_i(rd_rsp_valid), .rd_rsp_data_i(rd_rsp_data),
    .mv_start_o(mv_start), .mv_done_i(mv_done),
    .mv_src_dscr_o(mv_src), .mv_dst_dscr_o(mv_dst),
    .src_cur_o(src_cur), .dst_cur_o(dst_cur), .status_o(status), .en_o(en), .cont_o(cont),
    .ev_done_o(ev_done), .ev_src_done_o(ev_src_done), .ev_pause_o(ev_pause),
    .ev_src_err_o(ev_src_err), .ev_dst_err_o(ev_dst_err)
  );

  function automatic logic [127:0] mk(input logic [48:0] a, input logic [29:0] sz,
                                      input logic [1:0] cmd, input logic intr, input logic lnk);
    return {27'd0, cmd, intr, lnk, 1'b0, 2'd0, sz, 15'd0, a[48:32], a[31:0]};
  endfunction

  task automatic put(input int byte_addr, input logic [127:0] d);
    for (int i = 0; i < 4; i++) mem[(byte_addr >> 2) + i] = d[32*i +: 32];
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // response and mover models, driven at falling edges
  initial begin
    int pend_n = 0;
    logic [63:0] pend_a = '0;
    int mv_wait = 0;
    rd_rsp_valid = 1'b0; rd_rsp_data = '0; mv_done = 1'b0;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      mv_done = 1'b0;
      if (pend_n > 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[pend_a[8:2]];
        pend_a += 4;
        pend_n--;
      end else if (rd_req_valid) begin
        pend_a = rd_req_addr;
        pend_n = rd_req_ptr ? 2 : 4;
      end
      if (mv_wait == 1) mv_done = 1'b1;
      if (mv_wait > 0) mv_wait--;
      if (mv_start) mv_wait = 3;
    end
  end

  // counters sampled at rising edges
  initial forever begin
    @(posedge clk);
    if (rst_n) begin
      if (rd_req_valid && rd_req_ready) begin
        req_cnt++;
        if (rd_req_ptr) last_ptr_addr = rd_req_addr;
      end
      if (mv_start) begin start_cnt++; last_src = mv_src; last_dst = mv_dst; end
      if (ev_done) done_cnt++;
      if (ev_src_done) sdone_cnt++;
      if (ev_pause) pause_cnt++;
      if (ev_src_err) serr_cnt++;
      if (ev_dst_err) derr_cnt++;
    end
  end

  task automatic wr_ctrl(input logic e, input logic c, input logic s);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_en = e; ctrl_cont = c; ctrl_cs = s;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 400 && status == 2'd1; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 2'd0);
    chk("R1 en", en, 0);
    chk("R1 cont", cont, 0);
    chk("R1 req", rd_req_valid, 0);
    chk("R1 start", mv_start, 0);
  endtask

  task automatic t_reg_mode();
    int r0 = req_cnt, s0 = start_cnt, d0 = done_cnt, sd0 = sdone_cnt;
    mem_mode = 1'b0;
    src_reg = mk(49'h1_0000_2000, 30'h40, 2'd0, 1'b1, 1'b0);
    dst_reg = mk(49'h3000, 30'h40, 2'd0, 1'b0, 1'b0);
    src_start = 64'h200; dst_start = 64'h300;
    wr_ctrl(1, 0, 0);
    chk("R2 status after enable", status, 2'd1);
    chk("R2 en after enable", en, 1);
    settle();
    chk("R4 no requests", req_cnt - r0, 0);
    chk("R4 one start", start_cnt - s0, 1);
    chk("R4 src from register", last_src, src_reg);
    chk("R4 dst from register", last_dst, dst_reg);
    chk("R4 stops", status, 2'd0);
    chk("R4 en cleared", en, 0);
    chk("R5 done", done_cnt - d0, 1);
    chk("R5 src done", sdone_cnt - sd0, 1);
    chk("R2 src pointer loaded", src_cur, 64'h200);
  endtask

  task automatic t_linear();
    int r0 = req_cnt, s0 = start_cnt, d0 = done_cnt, sd0 = sdone_cnt;
    mem_mode = 1'b1; src_start = 64'h0; dst_start = 64'h80;
    wr_ctrl(1, 0, 0);
    chk("R2 status", status, 2'd1);
    settle();
    chk("R8 requests dst+2 src", req_cnt - r0, 3);
    chk("R8 two starts", start_cnt - s0, 2);
    chk("R3 src words", last_src, mk(49'h5000, 30'h30, 2'd2, 1'b1, 1'b0));
    chk("R3 dst words", last_dst, mk(49'h1_2345_6780, 30'h50, 2'd0, 1'b0, 1'b0));
    chk("R8 src pointer", src_cur, 64'h10);
    chk("R2 dst pointer", dst_cur, 64'h80);
    chk("R5 done x2", done_cnt - d0, 2);
    chk("R5 src done only flagged", sdone_cnt - sd0, 1);
    chk("R6 stop status", status, 2'd0);
    chk("R6 stop clears en", en, 0);
  endtask

  task automatic t_halt();
    int r0 = req_cnt, p0 = pause_cnt;
    src_start = 64'h40; dst_start = 64'h80;
    wr_ctrl(1, 0, 0);
    settle();
    chk("R7 paused", status, 2'd2);
    chk("R7 pause event", pause_cnt - p0, 1);
    chk("R7 pointer kept", src_cur, 64'h40);
    chk("R7 en kept", en, 1);
    chk("R7 requests", req_cnt - r0, 2);
  endtask

  task automatic t_ignore_enable();
    int r0 = req_cnt, s0 = start_cnt;
    wr_ctrl(1, 0, 0);
    chk("R12 still paused", status, 2'd2);
    repeat (10) @(negedge clk);
    chk("R12 no request", req_cnt - r0, 0);
    chk("R12 no start", start_cnt - s0, 0);
    chk("R12 still paused later", status, 2'd2);
  endtask

  task automatic t_resume_next();
    int r0 = req_cnt, s0 = start_cnt, sd0 = sdone_cnt;
    wr_ctrl(1, 1, 0);
    chk("R10 running", status, 2'd1);
    chk("R10 continue self-clears", cont, 0);
    settle();
    chk("R9 pointer read address", last_ptr_addr, 64'h50);
    chk("R9 pointer followed", src_cur, 64'hC0);
    chk("R9 requests", req_cnt - r0, 2);
    chk("R10 one start", start_cnt - s0, 1);
    chk("R9 linked target words", last_src, mk(49'h7000, 30'h22, 2'd2, 1'b1, 1'b0));
    chk("R5 src done", sdone_cnt - sd0, 1);
    chk("R6 stopped", status, 2'd0);
  endtask

  task automatic t_resume_start();
    int r0, p0;
    wr_ctrl(1, 0, 0);
    settle();
    chk("R7 paused again", status, 2'd2);
    r0 = req_cnt; p0 = pause_cnt;
    last_ptr_addr = '0;
    wr_ctrl(1, 1, 1);
    chk("R11 running", status, 2'd1);
    chk("R11 continue self-clears", cont, 0);
    settle();
    chk("R11 refetch dst and src", req_cnt - r0, 2);
    chk("R11 no pointer read", last_ptr_addr, 64'h0);
    chk("R11 pointer at start", src_cur, 64'h40);
    chk("R11 halted again", status, 2'd2);
    chk("R11 pause event", pause_cnt - p0, 1);
  endtask

  task automatic t_disable_from_pause();
    int r0 = req_cnt;
    wr_ctrl(0, 1, 0);
    chk("R12 disabled", status, 2'd0);
    repeat (10) @(negedge clk);
    chk("R12 no request after disable", req_cnt - r0, 0);
  endtask

  task automatic t_src_misalign();
    int r0 = req_cnt, e0 = serr_cnt, s0 = start_cnt;
    src_start = 64'h44; dst_start = 64'h80;
    wr_ctrl(1, 0, 0);
    settle();
    chk("R13 error status", status, 2'd3);
    chk("R13 src error event", serr_cnt - e0, 1);
    chk("R13 only dst requested", req_cnt - r0, 1);
    chk("R13 no start", start_cnt - s0, 0);
    src_start = 64'h0;
    wr_ctrl(1, 0, 0);
    chk("R13 error cleared on enable", status, 2'd1);
    settle();
    chk("R13 chain completes after clear", status, 2'd0);
  endtask

  task automatic t_dst_misalign();
    int r0 = req_cnt, e0 = derr_cnt;
    src_start = 64'h0; dst_start = 64'h88;
    wr_ctrl(1, 0, 0);
    settle();
    chk("R13 dst error status", status, 2'd3);
    chk("R13 dst error event", derr_cnt - e0, 1);
    chk("R13 no request", req_cnt - r0, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    put(16'h00, mk(49'h4000, 30'h20, 2'd0, 1'b0, 1'b0));
    put(16'h10, mk(49'h5000, 30'h30, 2'd2, 1'b1, 1'b0));
    put(16'h40, mk(49'h6000, 30'h11, 2'd1, 1'b0, 1'b1));
    mem[16'h50 >> 2] = 32'hC0;
    mem[16'h54 >> 2] = 32'h0;
    put(16'h80, mk(49'h1_2345_6780, 30'h50, 2'd0, 1'b0, 1'b0));
    put(16'hC0, mk(49'h7000, 30'h22, 2'd2, 1'b1, 1'b0));
    mem_mode = 1'b1; ctrl_we = 1'b0; ctrl_en = 1'b0; ctrl_cont = 1'b0; ctrl_cs = 1'b0;
    src_start = '0; dst_start = '0; src_reg = '0; dst_reg = '0; rd_req_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg_mode();
    t_linear();
    t_halt();
    t_ignore_enable();
    t_resume_next();
    t_resume_start();
    t_disable_from_pause();
    t_src_misalign();
    t_dst_misalign();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule